// File: doc/BRIEF.md
# Shared Interrupt Routing Controller

This block takes a parameterised set of external interrupt sources, shared by several processor cores, and turns each one into a request on a chosen pin of a chosen core. Per source, software picks an active polarity, level or edge sensing, and an optional dual-edge mode that latches on either transition. Enables are changed only through separate write-one-to-set and write-one-to-clear words, so two agents never need a read-modify-write to touch different sources.

Edge sources hold a sticky pending bit. Software clears it to acknowledge the interrupt, or sets it to send an inter-processor interrupt, through a single command word that names the source. Each source carries a routing word that selects one core and one output pin on that core, together with a valid flag. Every core/pin output is the OR of all sources that are pending, enabled and routed there. A plain single-cycle register bus gives access to configuration and state. Read data is returned on the cycle after the request.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every source is disabled, level sensed, positive polarity (polarity word bits read 1), not dual-edge, and has no pending edge. Every routing word reads 0: core 0, pin 0, valid flag clear. `irq_o` and `rdata_o` are 0.
- R2: A write to set-enable word w (address 0x30+w) enables each source whose bit is 1. A write to clear-enable word w (address 0x40+w) disables each source whose bit is 1. Zero bits change nothing. The enable state reads back at 0x20+w.
- R3: In level mode, the pending bit of a source equals its input when polarity is 1 and the inverted input when polarity is 0. It follows the input in the same cycle and does not latch.
- R4: In edge mode without dual-edge, a rising input edge (polarity 1) or a falling input edge (polarity 0) sets a sticky pending bit. The bit is visible from the cycle after the edge. The opposite transition does not set it.
- R5: In edge mode with dual-edge on, both transitions set the pending bit, whatever the polarity.
- R6: A write to the edge command word (address 0x01) names a source in bits [7:0]. Bit 31 set to 1 sets that source's edge pending bit, and set to 0 clears it. The command is ignored for an index at or above the source count and for a level-mode source. A hardware edge in the same cycle as a clear leaves the bit set.
- R7: The routing word of source n is at address 0x80+n. It holds the pin in bits [7:0], the core in bits [15:8] and the valid flag in bit 31, and reads back in the same layout. A source whose flag is clear, or whose core or pin is out of range, drives no output.
- R8: Output `irq_o[c*NUM_PIN+p]` is high exactly when at least one source is pending, enabled and validly routed to core c, pin p. It responds combinationally to pending and enable state.
- R9: The word at address 0x00 reads NUM_SRC/8-1 in bits [7:0], NUM_CORE-1 in bits [15:8], and 0 elsewhere.
- R10: The pending words (0x10+w) and enable words (0x20+w) place source n at bit n%32 of word n/32. Reads of write-only or unmapped addresses return 0.
- R11: The polarity (0x50+w), trigger (0x60+w, 1 = edge) and dual-edge (0x70+w) words are read/write, with the same bit placement as R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk_i |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | 8 | Bus word address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, valid the cycle after a read request |
| irq_o | output | NUM_CORE*NUM_PIN | Interrupt request per core pin |

## Verification
On every cycle, the assertions check several behaviours. The enable and routing state change only on their own write addresses. A pending edge rises only after a matching transition or a software set. A level-mode source holds no edge state. A dual-edge transition always latches. No output is raised without an enabled pending source. The configuration word is returned on any read of it. The bench scenarios show the rest. These are the bit placement across words, the polarity and trigger combinations, and the set-beats-clear race. They also cover ignored commands on level sources and out-of-range indices, the valid flag and out-of-range routing, and the OR of several sources onto one pin.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;

  // address page in addr[7:4], word offset in addr[3:0]; route words at 0x80+n
  localparam logic [3:0] PG_CTRL  = 4'h0;
  localparam logic [3:0] PG_PEND  = 4'h1;
  localparam logic [3:0] PG_MASK  = 4'h2;
  localparam logic [3:0] PG_SMASK = 4'h3;
  localparam logic [3:0] PG_CMASK = 4'h4;
  localparam logic [3:0] PG_POL   = 4'h5;
  localparam logic [3:0] PG_TRIG  = 4'h6;
  localparam logic [3:0] PG_DUAL  = 4'h7;
  localparam logic [3:0] OFS_CFG  = 4'h0;
  localparam logic [3:0] OFS_EDGE = 4'h1;
  localparam logic [7:0] ROUTE_BASE = 8'h80;
  localparam int unsigned EDGE_SET_BIT = 31;

  typedef struct packed {
    logic       valid;
    logic [7:0] core;
    logic [7:0] pin;
  } route_t;

  function automatic logic [DW-1:0] route_word(route_t r);
    return {r.valid, 15'b0, r.core, r.pin};
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  logic src_q, edge_q, rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= 1'b0;
    else         src_q <= src_i;
  end

  assign rise = src_i & ~src_q;
  assign fall = ~src_i & src_q;

  always_comb begin
    if (dual_i) hit = rise | fall;
    else        hit = pol_i ? rise : fall;
  end

  // hardware edge and software set take priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                edge_q <= 1'b0;
    else if (!trig_i)           edge_q <= 1'b0;
    else if (hit || sw_set_i)   edge_q <= 1'b1;
    else if (sw_clr_i)          edge_q <= 1'b0;
  end

  assign pend_o = trig_i ? edge_q : (pol_i ? src_i : ~src_i);

  // R6
  sw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_set_i && sw_clr_i));
  // R4
  edge_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_q) |-> $past(hit || sw_set_i));
  // R3
  level_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> !edge_q);
  // R5
  dual_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && dual_i && (src_i != src_q)) |=> edge_q);
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned NUM_CORE = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  input  logic [NUM_SRC-1:0]         pend_i,
  output logic [NUM_SRC-1:0]         mask_o,
  output logic [NUM_SRC-1:0]         pol_o,
  output logic [NUM_SRC-1:0]         trig_o,
  output logic [NUM_SRC-1:0]         dual_o,
  output logic [NUM_SRC-1:0]         sw_set_o,
  output logic [NUM_SRC-1:0]         sw_clr_o,
  output route_t [NUM_SRC-1:0]       route_o
);
  localparam int unsigned NSW = (NUM_SRC + DW - 1) / DW;
  localparam int unsigned PAD = NSW * DW;
  localparam logic [DW-1:0] CFG_WORD = {16'b0, 8'(NUM_CORE - 1), 8'(NUM_SRC / 8 - 1)};

  logic [3:0] page, ofs;
  logic       wr, rd, edge_wr;
  logic [NUM_SRC-1:0] mask_q, pol_q, trig_q, dual_q;
  route_t [NUM_SRC-1:0] route_q;
  logic [DW-1:0] rd_word, rdata_q;

  assign page    = addr_i[7:4];
  assign ofs     = addr_i[3:0];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign edge_wr = wr && page == PG_CTRL && ofs == OFS_EDGE;

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) begin
      sw_set_o[n] = edge_wr && wdata_i[7:0] == 8'(n) &&  wdata_i[EDGE_SET_BIT];
      sw_clr_o[n] = edge_wr && wdata_i[7:0] == 8'(n) && !wdata_i[EDGE_SET_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      pol_q   <= '1;
      trig_q  <= '0;
      dual_q  <= '0;
      route_q <= '0;
    end else if (wr) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (ofs == 4'(n / DW)) begin
          if (page == PG_SMASK && wdata_i[n % DW]) mask_q[n] <= 1'b1;
          if (page == PG_CMASK && wdata_i[n % DW]) mask_q[n] <= 1'b0;
          if (page == PG_POL)  pol_q[n]  <= wdata_i[n % DW];
          if (page == PG_TRIG) trig_q[n] <= wdata_i[n % DW];
          if (page == PG_DUAL) dual_q[n] <= wdata_i[n % DW];
        end
        if (addr_i == 8'(ROUTE_BASE + n))
          route_q[n] <= '{valid: wdata_i[31], core: wdata_i[15:8], pin: wdata_i[7:0]};
      end
    end
  end

  function automatic logic [DW-1:0] pick(input logic [PAD-1:0] v, input logic [3:0] o);
    logic [DW-1:0] r;
    r = '0;
    for (int w = 0; w < NSW; w++)
      if (o == 4'(w)) r = v[w*DW +: DW];
    return r;
  endfunction

  always_comb begin
    rd_word = '0;
    case (page)
      PG_CTRL: if (ofs == OFS_CFG) rd_word = CFG_WORD;
      PG_PEND: rd_word = pick(PAD'(pend_i), ofs);
      PG_MASK: rd_word = pick(PAD'(mask_q), ofs);
      PG_POL:  rd_word = pick(PAD'(pol_q), ofs);
      PG_TRIG: rd_word = pick(PAD'(trig_q), ofs);
      PG_DUAL: rd_word = pick(PAD'(dual_q), ofs);
      default: begin
        for (int n = 0; n < NUM_SRC; n++)
          if (addr_i == 8'(ROUTE_BASE + n)) rd_word = route_word(route_q[n]);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign dual_o  = dual_q;
  assign route_o = route_q;

  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (page == PG_SMASK || page == PG_CMASK)) |=> $stable(mask_q));
  // R7
  route_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && page[3]) |=> $stable(route_q));
  // R9
  cfg_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 8'h00) |=> rdata_o == CFG_WORD);
endmodule

// File: rtl/irq_core_out.sv
module irq_core_out
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned NUM_CORE = 2,
  parameter int unsigned NUM_PIN  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SRC-1:0]           act_i,
  input  route_t [NUM_SRC-1:0]         route_i,
  output logic [NUM_CORE*NUM_PIN-1:0]  irq_o
);
  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int n = 0; n < NUM_SRC; n++)
          if (act_i[n] && route_i[n].valid &&
              route_i[n].core == 8'(c) && route_i[n].pin == 8'(p))
            hit = 1'b1;
      end
      assign irq_o[c*NUM_PIN+p] = hit;
    end
  end

  // R8
  irq_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|act_i));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned NUM_CORE = 2,
  parameter int unsigned NUM_PIN  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SRC-1:0]           src_i,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [7:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output logic [NUM_CORE*NUM_PIN-1:0]  irq_o
);
  logic [NUM_SRC-1:0] pend, mask, pol, trig, dual, sw_set, sw_clr;
  route_t [NUM_SRC-1:0] route;

  irq_reg_file #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pend_i(pend), .mask_o(mask), .pol_o(pol), .trig_o(trig), .dual_o(dual),
    .sw_set_o(sw_set), .sw_clr_o(sw_clr), .route_o(route)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    irq_src_cell u_cell (
      .clk_i, .rst_ni, .src_i(src_i[n]), .pol_i(pol[n]), .trig_i(trig[n]),
      .dual_i(dual[n]), .sw_set_i(sw_set[n]), .sw_clr_i(sw_clr[n]), .pend_o(pend[n])
    );
  end

  irq_core_out #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_out (
    .clk_i, .rst_ni, .act_i(pend & mask), .route_i(route), .irq_o
  );
endmodule

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
module tb_irq_route_ctrl;
  localparam int NS = 40, NC = 2, NP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rd;
  logic [NC*NP-1:0] irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_route_ctrl #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rdw(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rd;
  endtask

  function automatic int bitpos(int n);
    return (n % 2) * NP + (n / 2) % NP;
  endfunction

  initial begin
    logic [31:0] v;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata", rd, 0);
    rdw(8'h20, v); chk("R1 mask0", v, 0);
    rdw(8'h21, v); chk("R1 mask1", v, 0);
    rdw(8'h50, v); chk("R1 pol0", v, 32'hFFFF_FFFF);
    rdw(8'h51, v); chk("R1 pol1", v, 32'h0000_00FF);
    rdw(8'h60, v); chk("R1 trig0", v, 0);
    rdw(8'h70, v); chk("R1 dual0", v, 0);
    rdw(8'h80, v); chk("R1 route0", v, 0);
    rdw(8'h10, v); chk("R1 pend0", v, 0);
    // R9 config word
    rdw(8'h00, v); chk("R9 cfg", v, {16'b0, 8'(NC-1), 8'(NS/8-1)});
    // R10 write-only reads as zero
    rdw(8'h30, v); chk("R10 wo read", v, 0);

    // R2 zero write does nothing, then set all
    wr(8'h30, 32'h0);
    rdw(8'h20, v); chk("R2 zero set", v, 0);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h31, 32'h0000_00FF);
    rdw(8'h21, v); chk("R2 mask1", v, 32'hFF);

    // R7 route every source
    for (int n = 0; n < NS; n++)
      wr(8'(8'h80 + n), {1'b1, 15'b0, 8'(n % 2), 8'((n / 2) % NP)});
    rdw(8'h83, v); chk("R7 route rb", v, 32'h8000_0101);

    // R3 R8 R10 level sweep
    for (int n = 0; n < NS; n++) begin
      @(negedge clk); src[n] = 1'b1; #1;
      chk($sformatf("R8 level src%0d", n), 32'(irq), 32'(1) << bitpos(n));
      rdw(8'(8'h10 + n / 32), v);
      chk($sformatf("R10 pend src%0d", n), v, 32'(1) << (n % 32));
      @(negedge clk); src[n] = 1'b0; #1;
      chk($sformatf("R3 no latch src%0d", n), 32'(irq), 0);
    end

    // R2 clear-enable
    wr(8'h40, 32'h1);
    wr(8'h40, 32'h0);
    rdw(8'h20, v); chk("R2 clr", v, 32'hFFFF_FFFE);
    @(negedge clk); src[0] = 1'b1; #1;
    chk("R2 masked irq", 32'(irq), 0);
    rdw(8'h10, v); chk("R2 masked pend", v, 32'h1);
    @(negedge clk); src[0] = 1'b0;
    wr(8'h30, 32'h1);

    // R3 negative level
    wr(8'h50, 32'hFFFF_FFFE); #1;
    chk("R3 neg low", 32'(irq), 32'h1);
    @(negedge clk); src[0] = 1'b1; #1;
    chk("R3 neg high", 32'(irq), 0);
    @(negedge clk); src[0] = 1'b0;
    wr(8'h50, 32'hFFFF_FFFF);

    // R4 positive edge, source 1 -> bit 4
    wr(8'h60, 32'h2);
    @(negedge clk); src[1] = 1'b1; #1;
    chk("R4 before reg", 32'(irq), 0);
    @(negedge clk);
    chk("R4 rise", 32'(irq), 32'h10);
    src[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R4 sticky", 32'(irq), 32'h10);
    wr(8'h01, 32'h0000_0001);
    chk("R6 clear", 32'(irq), 0);

    // R4 negative edge, source 2 -> bit 1
    wr(8'h50, 32'hFFFF_FFFB);
    wr(8'h60, 32'h6);
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 neg rise ignored", 32'(irq), 0);
    src[2] = 1'b0;
    @(negedge clk);
    chk("R4 neg fall", 32'(irq), 32'h2);
    wr(8'h01, 32'h0000_0002);
    chk("R6 clear2", 32'(irq), 0);

    // R5 dual edge, source 3 -> bit 5, polarity 0
    wr(8'h50, 32'hFFFF_FFF3);
    wr(8'h60, 32'hE);
    wr(8'h70, 32'h8);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk);
    chk("R5 dual rise", 32'(irq), 32'h20);
    wr(8'h01, 32'h0000_0003);
    chk("R5 cleared", 32'(irq), 0);
    @(negedge clk); src[3] = 1'b0;
    @(negedge clk);
    chk("R5 dual fall", 32'(irq), 32'h20);
    wr(8'h01, 32'h0000_0003);
    rdw(8'h60, v); chk("R11 trig rb", v, 32'hE);
    rdw(8'h70, v); chk("R11 dual rb", v, 32'h8);
    rdw(8'h50, v); chk("R11 pol rb", v, 32'hFFFF_FFF3);

    // R6 software set, ignored commands
    wr(8'h01, 32'h8000_0001);
    chk("R6 sw set", 32'(irq), 32'h10);
    wr(8'h01, 32'h0000_0001);
    wr(8'h01, 32'h8000_0004);
    chk("R6 level ignore irq", 32'(irq), 0);
    rdw(8'h10, v); chk("R6 level ignore pend", v, 0);
    wr(8'h01, 32'h8000_0028);
    rdw(8'h10, v); chk("R6 range pend0", v, 0);
    rdw(8'h11, v); chk("R6 range pend1", v, 0);

    // R6 edge beats same-cycle clear
    @(negedge clk); src[1] = 1'b1; req = 1; we = 1; addr = 8'h01; wdata = 32'h1;
    @(negedge clk); req = 0; we = 0;
    chk("R6 edge wins", 32'(irq), 32'h10);
    src[1] = 1'b0;
    wr(8'h01, 32'h0000_0001);

    // R7 valid flag and out-of-range core
    wr(8'h84, 32'h0000_0002);
    @(negedge clk); src[4] = 1'b1; #1;
    chk("R7 invalid", 32'(irq), 0);
    rdw(8'h10, v); chk("R7 pend", v, 32'h10);
    wr(8'h84, 32'h8000_0202);
    chk("R7 bad core", 32'(irq), 0);
    wr(8'h84, 32'h8000_0103);
    chk("R7 reroute", 32'(irq), 32'h80);
    rdw(8'h84, v); chk("R7 rb", v, 32'h8000_0103);
    @(negedge clk); src[4] = 1'b0;

    // R8 OR of two sources on core0 pin0
    @(negedge clk); src[0] = 1'b1; src[8] = 1'b1; #1;
    chk("R8 both", 32'(irq), 32'h1);
    @(negedge clk); src[0] = 1'b0; #1;
    chk("R8 one left", 32'(irq), 32'h1);
    @(negedge clk); src[8] = 1'b0; #1;
    chk("R8 none", 32'(irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule